// File: doc/BRIEF.md
# Segmented SIMD Integer ALU

This block is a wide integer ALU built from 1-bit slices that can be split into packed lanes. A small size code supplied with every operation picks the lane width as a power of two. A decoder turns that code into a comb of break points at every lane edge. At each break the carry chain and the shift paths are cut, so a single pass applies the same operation to every lane independently.

Operations are accepted on a valid/ready input stream and leave on a valid/ready output stream through one result register. An accepted operation appears at the output on the next cycle. The input is ready whenever the output register is empty or is being emptied in the same cycle, so a full pipeline sustains one result per clock. When the consumer holds `out_ready` low, the result stays frozen and `in_ready` drops, which stalls the producer. Compare-equal returns its per-lane verdict twice: once spread across the lane's bits in the result, and once packed into a flag vector with one bit per lane.

Top module: `seg_simd_alu`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: The lane width is 2^`in_size` bits. Size codes 8 to 15 all select a single 256-bit lane.
- R3: Opcode 0 (add) gives the sum of each lane pair modulo 2^width. No carry crosses a lane edge.
- R4: Opcode 1 (subtract) gives a minus b in each lane modulo 2^width. No borrow crosses a lane edge.
- R5: Opcode 2 (shift left) shifts every lane of a left by the amount in `in_b[7:0]`. Zeros enter at the lane's low end, and bits leaving the lane are lost. An amount equal to or larger than the lane width gives zero.
- R6: Opcode 3 (shift right, logical) works like R5 in the other direction. Zeros enter at the lane's high end.
- R7: Opcodes 4, 5 and 6 give the bitwise AND, OR and XOR of a and b.
- R8: Opcode 7 (compare equal) sets every bit of a lane to 1 when the two lanes are equal and to 0 otherwise. Flag bit k holds lane k's verdict, where lane 0 is the least significant lane, and flag bits at or above the lane count are 0.
- R9: For every opcode other than 7, `out_flags` is all zeros.
- R10: An operation accepted on a rising edge drives `out_valid` high after that edge with its result. With `out_ready` held high, back-to-back operations complete one per cycle.
- R11: While `out_valid` is 1 and `out_ready` is 0, the result and flags hold steady, `in_ready` is 0, and no new operation is taken in.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be taken this cycle |
| in_op | input | 3 | Opcode (0 add, 1 sub, 2 shl, 3 shr, 4 and, 5 or, 6 xor, 7 cmpeq) |
| in_size | input | 4 | Lane size code, width 2^code bits |
| in_a | input | 256 | First operand |
| in_b | input | 256 | Second operand; low 8 bits give the shift amount |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 256 | Lane-wise result |
| out_flags | output | 256 | Compare verdict per lane, zero for other opcodes |

## Verification
On every cycle the assertions check the stream rules: an accepted operation produces a valid output, a stalled output holds still, flags stay empty outside compares, and flag bit 0 agrees with the lowest result bit after a compare. They also check that a clamped, single-lane add equals a plain full-width sum. Per-lane arithmetic is left to the bench's scenarios. These cover carries and borrows stopping at edges of various widths, shifts whose amount reaches or passes the lane width, and compares where only some lanes match. The bench scores them against a lane-by-lane model it computes itself.

// File: rtl/seg_alu_pkg.sv
package seg_alu_pkg;
  localparam int ALU_W  = 256;
  localparam int SIZE_W = 4;
  localparam int LOG_W  = $clog2(ALU_W);
  localparam int EXP_W  = $clog2(LOG_W + 1);

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_SHL = 3'd2,
    OP_SHR = 3'd3,
    OP_AND = 3'd4,
    OP_OR  = 3'd5,
    OP_XOR = 3'd6,
    OP_CEQ = 3'd7
  } alu_op_e;
endpackage

// File: rtl/seg_lane_decode.sv
module seg_lane_decode #(
  parameter int DATA_W = 256,
  parameter int CODE_W = 4,
  localparam int LOGW  = $clog2(DATA_W),
  localparam int EW    = $clog2(LOGW + 1)
) (
  input  logic [CODE_W-1:0] size_code,
  output logic [EW-1:0]     lane_exp,
  output logic [DATA_W-1:0] lane_brk
);
  // Clamp codes that describe lanes wider than the datapath.
  always_comb begin
    if (int'(size_code) > LOGW) lane_exp = EW'(LOGW);
    else                        lane_exp = EW'(size_code);
  end

  // Break at every bit index that is a multiple of the lane width.
  always_comb begin
    int lw;
    lw = 1 << int'(lane_exp);
    for (int i = 0; i < DATA_W; i++) begin
      lane_brk[i] = ((i % lw) == 0);
    end
  end
endmodule

// File: rtl/seg_adder.sv
module seg_adder #(
  parameter int DATA_W = 256
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              sub,
  input  logic [DATA_W-1:0] brk,
  output logic [DATA_W-1:0] sum
);
  // Slice-by-slice ripple: at a break the incoming carry is replaced by
  // the lane's own carry-in (1 for subtract, 0 for add).
  always_comb begin
    logic c;
    logic cin;
    logic bb;
    c = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      cin    = brk[i] ? sub : c;
      bb     = b[i] ^ sub;
      sum[i] = a[i] ^ bb ^ cin;
      c      = (a[i] & bb) | (a[i] & cin) | (bb & cin);
    end
  end
endmodule

// File: rtl/seg_shifter.sv
module seg_shifter #(
  parameter int DATA_W = 256,
  localparam int LOGW  = $clog2(DATA_W),
  localparam int EW    = $clog2(LOGW + 1)
) (
  input  logic [DATA_W-1:0] x,
  input  logic [LOGW-1:0]   amt,
  input  logic [EW-1:0]     lane_exp,
  input  logic              to_right,
  output logic [DATA_W-1:0] y
);
  logic [DATA_W-1:0] stage_v [0:LOGW];

  assign stage_v[0] = x;

  // Log shifter; each stage masks off bits that would leave their lane.
  for (genvar s = 0; s < LOGW; s++) begin : g_stage
    logic [DATA_W-1:0] moved;
    logic [DATA_W-1:0] keep;
    always_comb begin
      int lw;
      int pos;
      lw = 1 << int'(lane_exp);
      if (to_right) moved = stage_v[s] >> (1 << s);
      else          moved = stage_v[s] << (1 << s);
      for (int i = 0; i < DATA_W; i++) begin
        pos = i % lw;
        if (to_right) keep[i] = (pos + (1 << s)) < lw;
        else          keep[i] = pos >= (1 << s);
      end
    end
    assign stage_v[s+1] = amt[s] ? (moved & keep) : stage_v[s];
  end

  assign y = stage_v[LOGW];
endmodule

// File: rtl/seg_compare.sv
module seg_compare #(
  parameter int DATA_W = 256,
  localparam int LOGW  = $clog2(DATA_W),
  localparam int EW    = $clog2(LOGW + 1)
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [EW-1:0]     lane_exp,
  output logic [DATA_W-1:0] spread,
  output logic [DATA_W-1:0] flags
);
  logic [DATA_W-1:0] eq_lvl [0:LOGW];

  assign eq_lvl[0] = ~(a ^ b);

  // Level l holds one equality bit per 2^l-bit lane, packed from bit 0.
  for (genvar l = 1; l <= LOGW; l++) begin : g_lvl
    localparam int CNT = DATA_W >> l;
    logic [DATA_W-1:0] v;
    always_comb begin
      v = '0;
      for (int j = 0; j < CNT; j++) begin
        v[j] = eq_lvl[l-1][2*j] & eq_lvl[l-1][2*j+1];
      end
    end
    assign eq_lvl[l] = v;
  end

  always_comb begin
    flags = eq_lvl[lane_exp];
    for (int i = 0; i < DATA_W; i++) begin
      spread[i] = flags[i >> int'(lane_exp)];
    end
  end
endmodule

// File: rtl/seg_simd_alu.sv
module seg_simd_alu
  import seg_alu_pkg::*;
#(
  parameter int DATA_W = ALU_W,
  parameter int CODE_W = SIZE_W,
  localparam int LOGW  = $clog2(DATA_W),
  localparam int EW    = $clog2(LOGW + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [2:0]        in_op,
  input  logic [CODE_W-1:0] in_size,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_result,
  output logic [DATA_W-1:0] out_flags
);
  alu_op_e           op;
  logic [EW-1:0]     lane_exp;
  logic [DATA_W-1:0] lane_brk;
  logic [DATA_W-1:0] sum_v;
  logic [DATA_W-1:0] sh_v;
  logic [DATA_W-1:0] ceq_spread;
  logic [DATA_W-1:0] ceq_flags;
  logic [DATA_W-1:0] res_d;
  logic [DATA_W-1:0] flg_d;
  alu_op_e           op_q;
  logic              take;

  assign op = alu_op_e'(in_op);

  seg_lane_decode #(.DATA_W(DATA_W), .CODE_W(CODE_W)) u_dec (
    .size_code (in_size),
    .lane_exp  (lane_exp),
    .lane_brk  (lane_brk)
  );

  seg_adder #(.DATA_W(DATA_W)) u_add (
    .a   (in_a),
    .b   (in_b),
    .sub (op == OP_SUB),
    .brk (lane_brk),
    .sum (sum_v)
  );

  seg_shifter #(.DATA_W(DATA_W)) u_shf (
    .x        (in_a),
    .amt      (in_b[LOGW-1:0]),
    .lane_exp (lane_exp),
    .to_right (op == OP_SHR),
    .y        (sh_v)
  );

  seg_compare #(.DATA_W(DATA_W)) u_cmp (
    .a        (in_a),
    .b        (in_b),
    .lane_exp (lane_exp),
    .spread   (ceq_spread),
    .flags    (ceq_flags)
  );

  always_comb begin
    unique case (op)
      OP_ADD, OP_SUB: res_d = sum_v;
      OP_SHL, OP_SHR: res_d = sh_v;
      OP_AND:         res_d = in_a & in_b;
      OP_OR:          res_d = in_a | in_b;
      OP_XOR:         res_d = in_a ^ in_b;
      default:        res_d = ceq_spread;
    endcase
    flg_d = (op == OP_CEQ) ? ceq_flags : '0;
  end

  // Single output register with pass-through ready.
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_flags  <= '0;
      op_q       <= OP_ADD;
    end else if (take) begin
      out_valid  <= 1'b1;
      out_result <= res_d;
      out_flags  <= flg_d;
      op_q       <= op;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end

  AST_ACCEPT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid);  // R10
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) && $stable(out_flags)));  // R11
  AST_FLAGS_ONLY_CMP: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && op_q != OP_CEQ) |-> (out_flags == '0));  // R9
  AST_CMP_LANE0: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && op_q == OP_CEQ) |-> (out_flags[0] == out_result[0]));  // R8
  AST_WHOLE_ADD: assert property (@(posedge clk) disable iff (!rst_n)
    (take && op == OP_ADD && int'(in_size) >= LOGW) |=> (out_result == $past(in_a + in_b)));  // R2
endmodule

// File: tb/seg_simd_alu_bench.sv
module seg_simd_alu_bench;
  localparam int W = 256;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [2:0]   in_op = '0;
  logic [3:0]   in_size = '0;
  logic [W-1:0] in_a = '0;
  logic [W-1:0] in_b = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [W-1:0] out_result;
  logic [W-1:0] out_flags;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  seg_simd_alu u_seg_simd_alu (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_size(in_size), .in_a(in_a), .in_b(in_b),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result), .out_flags(out_flags)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] rnd();
    logic [W-1:0] v;
    for (int i = 0; i < W / 32; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  // Lane-by-lane model written from the requirements.
  task automatic model(input logic [2:0] op, input logic [3:0] sz,
                       input logic [W-1:0] a, input logic [W-1:0] b,
                       output logic [W-1:0] res, output logic [W-1:0] flg);
    int e, w, n, sh;
    logic [W-1:0] m, ea, eb, r;
    e = (sz > 8) ? 8 : int'(sz);
    w = 1 << e;
    n = W / w;
    m = (w == W) ? '1 : ((W'(1) << w) - 1);
    sh = int'(b[7:0]);
    res = '0;
    flg = '0;
    for (int k = 0; k < n; k++) begin
      ea = (a >> (k * w)) & m;
      eb = (b >> (k * w)) & m;
      case (op)
        3'd0: r = (ea + eb) & m;
        3'd1: r = (ea - eb) & m;
        3'd2: r = (sh >= w) ? '0 : ((ea << sh) & m);
        3'd3: r = (sh >= w) ? '0 : (ea >> sh);
        3'd4: r = ea & eb;
        3'd5: r = ea | eb;
        3'd6: r = ea ^ eb;
        default: begin
          r = (ea == eb) ? m : '0;
          flg[k] = (ea == eb);
        end
      endcase
      res = res | (r << (k * w));
    end
  endtask

  task automatic run_op(input string req, input logic [2:0] op, input logic [3:0] sz,
                        input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W-1:0] er, ef;
    model(op, sz, a, b, er, ef);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_size = sz; in_a = a; in_b = b;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " valid"}, W'(out_valid), W'(1));
    check({req, " result"}, out_result, er);
    check({req, " flags"}, out_flags, ef);
  endtask

  task automatic t_reset();
    check("R1 out_valid", W'(out_valid), W'(0));
    check("R1 in_ready", W'(in_ready), W'(1));
  endtask

  task automatic t_add();
    run_op("R3 add 8-bit carry stop", 3'd0, 4'd3, {32{8'hFF}}, {32{8'h01}});
    run_op("R3 add 1-bit", 3'd0, 4'd0, rnd(), rnd());
    run_op("R3 add 64-bit", 3'd0, 4'd6, {4{64'hFFFF_FFFF_FFFF_FFFF}}, {4{64'h1}});
    run_op("R2 add 128-bit", 3'd0, 4'd7, rnd(), rnd());
    run_op("R2 add code 8 single lane", 3'd0, 4'd8, {W{1'b1}}, W'(1));
    run_op("R2 add code 13 clamped", 3'd0, 4'd13, rnd(), rnd());
  endtask

  task automatic t_sub();
    run_op("R4 sub 8-bit borrow stop", 3'd1, 4'd3, {W{1'b0}}, {32{8'h01}});
    run_op("R4 sub 16-bit", 3'd1, 4'd4, rnd(), rnd());
    run_op("R4 sub 256-bit", 3'd1, 4'd15, rnd(), rnd());
  endtask

  task automatic t_shift();
    logic [W-1:0] b;
    b = rnd();
    b[7:0] = 8'd3;
    run_op("R5 shl 8-bit by 3", 3'd2, 4'd3, {32{8'hFF}}, b);
    b[7:0] = 8'd8;
    run_op("R5 shl amount equals width", 3'd2, 4'd3, rnd(), b);
    b[7:0] = 8'd200;
    run_op("R5 shl 256-bit by 200", 3'd2, 4'd8, rnd(), b);
    b[7:0] = 8'd5;
    run_op("R6 shr 16-bit by 5", 3'd3, 4'd4, {16{16'h8001}}, b);
    b[7:0] = 8'd40;
    run_op("R6 shr amount over width", 3'd3, 4'd5, rnd(), b);
    b[7:0] = 8'd1;
    run_op("R6 shr 2-bit lanes", 3'd3, 4'd1, rnd(), b);
  endtask

  task automatic t_logic();
    run_op("R7 and", 3'd4, 4'd2, rnd(), rnd());
    run_op("R7 or", 3'd5, 4'd9, rnd(), rnd());
    run_op("R7 xor", 3'd6, 4'd0, rnd(), rnd());
  endtask

  task automatic t_cmp();
    logic [W-1:0] a;
    a = rnd();
    run_op("R8 cmpeq bytes half match", 3'd7, 4'd3, a, a ^ {16{16'h0001}});
    run_op("R8 cmpeq all 1-bit lanes", 3'd7, 4'd0, a, rnd());
    run_op("R8 cmpeq 32-bit all equal", 3'd7, 4'd5, a, a);
    run_op("R8 cmpeq 256-bit unequal", 3'd7, 4'd11, a, a ^ (W'(1) << 255));
    run_op("R9 flags zero after add", 3'd0, 4'd3, a, a);
  endtask

  task automatic t_stream();
    logic [W-1:0] a1, a2, b1, b2, r1, r2, f;
    a1 = rnd(); b1 = rnd(); a2 = rnd(); b2 = rnd();
    model(3'd0, 4'd4, a1, b1, r1, f);
    model(3'd6, 4'd4, a2, b2, r2, f);
    // back-to-back throughput
    @(negedge clk);
    in_valid = 1'b1; in_op = 3'd0; in_size = 4'd4; in_a = a1; in_b = b1;
    @(negedge clk);
    check("R10 first result", out_result, r1);
    in_op = 3'd6; in_a = a2; in_b = b2;
    @(negedge clk);
    in_valid = 1'b0;
    check("R10 second result next cycle", out_result, r2);
    check("R10 valid", W'(out_valid), W'(1));
    @(negedge clk);
    check("R10 drains", W'(out_valid), W'(0));
    // stall
    out_ready = 1'b0;
    in_valid = 1'b1; in_op = 3'd0; in_size = 4'd4; in_a = a1; in_b = b1;
    @(negedge clk);
    in_op = 3'd6; in_a = a2; in_b = b2;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R11 held result", out_result, r1);
      check("R11 in_ready low", W'(in_ready), W'(0));
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R11 next op after release", out_result, r2);
    @(negedge clk);
    check("R11 empties", W'(out_valid), W'(0));
  endtask

  initial begin
    repeat (120000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_add();
    t_sub();
    t_shift();
    t_logic();
    t_cmp();
    t_stream();
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule